// File: doc/BRIEF.md
# Decimating Converter with Serial Readout

This block turns a single-bit sigma-delta modulator stream into a 15-bit offset-binary result. It returns that result over a three-wire serial port made of a conversion-start strobe, a shift clock and a data line. There are two modulator inputs, each with its own clock and data. A channel-select level picks which input is converted. Every input runs in the block's system clock domain: the block samples each control and modulator line and detects its edges there.

A conversion averages the selected bitstream with a triangular weight that climbs from 1 to M and then falls back to 1. The window length M comes from a per-channel mode code. The data line itself carries the handshake. It drives low while the converter is busy and high when the result is ready, and then shifts out the word on falling shift-clock edges.

Each channel also has an offset register. A conversion run with the channel's calibration bit set stores its uncalibrated result there. Every later result on that channel has the stored value removed, with saturation at the code limits.

Top module: `decim_serial_conv`

## Requirements
- R1: A falling edge on `conv_ni` starts a conversion. The level of `chan_sel_i` at that moment (0 = input A, 1 = input B) selects the modulator for the whole cycle. Data on the other input has no effect on the result.
- R2: Out of reset and while idle, `sdat_oe_o` and `sdat_o` are 0. From the start of a conversion until the result is ready, `sdat_oe_o` is 1 and `sdat_o` is 0. At ready, `sdat_o` goes to 1.
- R3: A conversion consumes 2M-1 rising edges of the selected modulator clock, with M set by the channel's 4-bit mode code: 0101 gives 256, 0011 gives 128, 1110 gives 64, 1100 gives 32, 1010 gives 16.
- R4: Sample i of the window (counting from 0) carries weight i+1 for i < M and weight 2M-1-i after that. A modulator 1 adds its weight and a 0 adds nothing. The raw code is floor(sum * 2^15 / M^2), saturated to 32767, so a bitstream of density k/16 gives raw k*2048.
- R5: After ready, each falling `sclk_i` edge presents the next bit. A receiver sampling before each fall sees 16 bits: a leading 1, then result bits 14 down to 0. The line then stays low until `conv_ni` rises.
- R6: A rising edge on `conv_ni` returns the port to idle from any state within 3 system clocks. This applies mid-conversion, mid-shift or after the shift completes, and it drops `sdat_oe_o`.
- R7: A configuration write (`cfg_we_i`) sets the mode code and calibration bit of channel `cfg_chan_i`. A write with a code outside the five of R3 is ignored entirely. Reset leaves both channels at code 0101 with calibration off.
- R8: A conversion finishing with its channel's calibration bit set stores its raw code in that channel's offset register and reports the raw code. The most recent such conversion wins.
- R9: With calibration off, the reported code is raw - offset + 16384, clamped to 0..32767. Reset sets both offset registers to 16384, which subtracts nothing. Each channel uses only its own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mclk_a_i | input | 1 | Modulator A clock |
| mdat_a_i | input | 1 | Modulator A data, taken on rising mclk_a_i |
| mclk_b_i | input | 1 | Modulator B clock |
| mdat_b_i | input | 1 | Modulator B data, taken on rising mclk_b_i |
| chan_sel_i | input | 1 | Channel select (0 = A, 1 = B) |
| conv_ni | input | 1 | Conversion strobe, active low |
| sclk_i | input | 1 | Shift clock; data advances on falling edges |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_chan_i | input | 1 | Channel addressed by a configuration write |
| cfg_mode_i | input | 4 | Mode code for the write |
| cfg_cal_i | input | 1 | Calibration bit for the write |
| sdat_o | output | 1 | Serial data / busy-ready indication |
| sdat_oe_o | output | 1 | Output enable of the data line |

## Verification
The assertions watch every cycle for the following properties. The data line starts each cycle low. It releases only while the strobe is high. It never shows a 1 while undriven. The mode registers never hold a code outside the five accepted ones. The offset registers change only on a finishing conversion.

Only the bench scenarios can show the numeric results. They sweep every mode against a set of periodic densities and measure the busy time per mode. They also cover the offset capture and its effect on later results, both clamp limits, channel isolation, and aborts from the busy and shift phases.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int unsigned RES_W     = 15;
  localparam int unsigned LOG_M_MAX = 8;
  localparam int unsigned ACC_W     = 2 * LOG_M_MAX + 1;
  localparam int unsigned LOGM_W    = 4;
  localparam int unsigned NCH       = 2;
  localparam logic [3:0]  MODE_RST  = 4'b0101;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_SHIFT, ST_DONE} port_st_e;

  function automatic logic mode_valid(input logic [3:0] code);
    case (code)
      4'b0101, 4'b0011, 4'b1110, 4'b1100, 4'b1010: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LOGM_W-1:0] mode_log(input logic [3:0] code);
    case (code)
      4'b0011: return 4'd7;
      4'b1110: return 4'd6;
      4'b1100: return 4'd5;
      4'b1010: return 4'd4;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/decim_sync.sv
module decim_sync #(
  parameter int unsigned N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o  <= RST_VAL;
      prev_o <= RST_VAL;
    end else begin
      lvl_o  <= d_i;
      prev_o <= lvl_o;
    end
  end
endmodule

// File: rtl/decim_tri_acc.sv
// Triangular window 1..M..1, equal to two cascaded length-M boxcars.
module decim_tri_acc #(
  parameter int unsigned LOG_M_MAX = 8,
  parameter int unsigned ACC_W     = 2 * LOG_M_MAX + 1,
  parameter int unsigned LOGM_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [LOGM_W-1:0] log_m_i,
  input  logic              smp_i,
  input  logic              dat_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              done_o
);
  localparam int unsigned WGT_W = LOG_M_MAX + 1;

  logic [WGT_W-1:0] w_q;
  logic             up_q, act_q;
  logic [WGT_W-1:0] m_len;

  assign m_len = WGT_W'(1) << log_m_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      w_q    <= '0;
      up_q   <= 1'b0;
      act_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        acc_o <= '0;
        w_q   <= WGT_W'(1);
        up_q  <= 1'b1;
        act_q <= 1'b1;
      end else if (stop_i) begin
        act_q <= 1'b0;
      end else if (act_q && smp_i) begin
        acc_o <= acc_o + (dat_i ? ACC_W'(w_q) : '0);
        if (up_q) begin
          if (w_q == m_len) begin
            up_q <= 1'b0;
            w_q  <= w_q - 1'b1;
          end else begin
            w_q <= w_q + 1'b1;
          end
        end else if (w_q == WGT_W'(1)) begin
          act_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          w_q <= w_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/decim_post.sv
// Scale weighted sum to RES_W bits, then remove offset around midscale.
module decim_post #(
  parameter int unsigned RES_W  = 15,
  parameter int unsigned ACC_W  = 17,
  parameter int unsigned LOGM_W = 4
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [LOGM_W-1:0] log_m_i,
  input  logic [RES_W-1:0]  off_i,
  output logic [RES_W-1:0]  raw_o,
  output logic [RES_W-1:0]  cal_o
);
  localparam int unsigned SC_W = ACC_W + RES_W;
  localparam int unsigned DW   = RES_W + 2;
  localparam logic [DW-1:0] MID = DW'(1) << (RES_W - 1);

  logic [SC_W-1:0] scaled;
  logic [LOGM_W:0] sh;
  logic [DW-1:0]   diff;

  assign sh     = {log_m_i, 1'b0};
  assign scaled = {acc_i, {RES_W{1'b0}}} >> sh;

  always_comb begin
    if (|scaled[SC_W-1:RES_W]) raw_o = '1;
    else                       raw_o = scaled[RES_W-1:0];
    diff = {2'b00, raw_o} - {2'b00, off_i} + MID;
    if (diff[DW-1])      cal_o = '0;
    else if (diff[DW-2]) cal_o = '1;
    else                 cal_o = diff[RES_W-1:0];
  end
endmodule

// File: rtl/decim_serial_conv.sv
module decim_serial_conv
  import decim_pkg::*;
#(
  parameter int unsigned P_RES_W     = RES_W,
  parameter int unsigned P_LOG_M_MAX = LOG_M_MAX
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mclk_a_i,
  input  logic       mdat_a_i,
  input  logic       mclk_b_i,
  input  logic       mdat_b_i,
  input  logic       chan_sel_i,
  input  logic       conv_ni,
  input  logic       sclk_i,
  input  logic       cfg_we_i,
  input  logic       cfg_chan_i,
  input  logic [3:0] cfg_mode_i,
  input  logic       cfg_cal_i,
  output logic       sdat_o,
  output logic       sdat_oe_o
);
  localparam int unsigned P_ACC_W = 2 * P_LOG_M_MAX + 1;
  localparam int unsigned CNT_W   = $clog2(P_RES_W + 1);
  localparam logic [P_RES_W-1:0] OFF_RST = P_RES_W'(1) << (P_RES_W - 1);

  // sync bits: 0 strobe, 1 shift clock, 2 mclk A, 3 mclk B
  logic [3:0] lvl, prev;
  logic [1:0] dat_q;
  logic cs_fall, cs_rise, sclk_fall, rise_a, rise_b;

  decim_sync #(.N(4), .RST_VAL(4'b0001)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mclk_b_i, mclk_a_i, sclk_i, conv_ni}),
    .lvl_o (lvl),
    .prev_o(prev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dat_q <= '0;
    else         dat_q <= {mdat_b_i, mdat_a_i};
  end

  assign cs_fall   = prev[0] & ~lvl[0];
  assign cs_rise   = ~prev[0] & lvl[0];
  assign sclk_fall = prev[1] & ~lvl[1];
  assign rise_a    = lvl[2] & ~prev[2];
  assign rise_b    = lvl[3] & ~prev[3];

  logic [NCH-1:0][3:0]         mode_q;
  logic [NCH-1:0]              cal_q;
  logic [NCH-1:0][P_RES_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        mode_q[c] <= MODE_RST;
        cal_q[c]  <= 1'b0;
      end
    end else if (cfg_we_i && mode_valid(cfg_mode_i)) begin
      mode_q[cfg_chan_i] <= cfg_mode_i;
      cal_q[cfg_chan_i]  <= cfg_cal_i;
    end
  end

  port_st_e              st_q;
  logic                  chan_q;
  logic [LOGM_W-1:0]     logm_q;
  logic [P_RES_W:0]      sreg_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  start_acc, acc_done;
  logic [P_ACC_W-1:0]    acc;
  logic [P_RES_W-1:0]    raw, cal;

  assign start_acc = (st_q == ST_IDLE) && cs_fall;

  decim_tri_acc #(.LOG_M_MAX(P_LOG_M_MAX), .ACC_W(P_ACC_W), .LOGM_W(LOGM_W)) acc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_acc),
    .stop_i (cs_rise),
    .log_m_i(logm_q),
    .smp_i  (chan_q ? rise_b : rise_a),
    .dat_i  (chan_q ? dat_q[1] : dat_q[0]),
    .acc_o  (acc),
    .done_o (acc_done)
  );

  decim_post #(.RES_W(P_RES_W), .ACC_W(P_ACC_W), .LOGM_W(LOGM_W)) post_i (
    .acc_i  (acc),
    .log_m_i(logm_q),
    .off_i  (off_q[chan_q]),
    .raw_o  (raw),
    .cal_o  (cal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      chan_q <= 1'b0;
      logm_q <= mode_log(MODE_RST);
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (cs_rise) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cs_fall) begin
          st_q   <= ST_BUSY;
          chan_q <= chan_sel_i;
          logm_q <= mode_log(mode_q[chan_sel_i]);
        end
        ST_BUSY: if (acc_done) begin
          st_q   <= ST_SHIFT;
          sreg_q <= {1'b1, cal_q[chan_q] ? raw : cal};
          cnt_q  <= '0;
        end
        ST_SHIFT: if (sclk_fall) begin
          sreg_q <= sreg_q << 1;
          if (cnt_q == CNT_W'(P_RES_W)) st_q <= ST_DONE;
          else                         cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) off_q[c] <= OFF_RST;
    end else if (st_q == ST_BUSY && acc_done && !cs_rise && cal_q[chan_q]) begin
      off_q[chan_q] <= raw;
    end
  end

  assign sdat_oe_o = (st_q != ST_IDLE);
  assign sdat_o    = (st_q == ST_SHIFT) & sreg_q[P_RES_W];
endmodule

// File: rtl/decim_serial_conv_chk.sv
module decim_serial_conv_chk
  import decim_pkg::*;
#(
  parameter int unsigned P_RES_W = RES_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       conv_ni,
  input logic                       sdat_o,
  input logic                       sdat_oe_o,
  input logic [NCH-1:0][3:0]        mode_q,
  input logic [NCH-1:0][P_RES_W-1:0] off_q,
  input logic                       acc_done
);
  assert_busy_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdat_oe_o) |-> !sdat_o);

  assert_release_on_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdat_oe_o) |-> conv_ni);

  assert_undriven_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdat_o |-> sdat_oe_o);

  assert_mode_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_valid(mode_q[0]) && mode_valid(mode_q[1]));

  assert_offset_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_done |=> $stable(off_q));
endmodule

bind decim_serial_conv decim_serial_conv_chk #(.P_RES_W(P_RES_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .conv_ni  (conv_ni),
  .sdat_o   (sdat_o),
  .sdat_oe_o(sdat_oe_o),
  .mode_q   (mode_q),
  .off_q    (off_q),
  .acc_done (acc_done)
);

// File: tb/decim_serial_conv_tb.sv
module decim_serial_conv_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mclk_a = 1'b0, mdat_a = 1'b0, mclk_b = 1'b0, mdat_b = 1'b0;
  logic chan_sel = 1'b0, conv_n = 1'b1, sclk = 1'b0;
  logic cfg_we = 1'b0, cfg_chan = 1'b0, cfg_cal = 1'b0;
  logic [3:0] cfg_mode = 4'b0101;
  logic sdat, sdat_oe;

  int n_run = 0, n_fail = 0;
  int dens_a = 0, dens_b = 0;

  always #5 clk = ~clk;

  decim_serial_conv dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .mclk_a_i(mclk_a), .mdat_a_i(mdat_a), .mclk_b_i(mclk_b), .mdat_b_i(mdat_b),
    .chan_sel_i(chan_sel), .conv_ni(conv_n), .sclk_i(sclk),
    .cfg_we_i(cfg_we), .cfg_chan_i(cfg_chan), .cfg_mode_i(cfg_mode), .cfg_cal_i(cfg_cal),
    .sdat_o(sdat), .sdat_oe_o(sdat_oe)
  );

  function automatic logic pat_bit(input int j, input int k);
    return (((j + 1) * k) / 16 - (j * k) / 16) != 0;
  endfunction

  // modulators: period 4 system clocks, data changes on modulator falling edge
  initial begin
    int ph = 0;
    int ja = 0;
    int jb = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      if (ph == 0) begin
        mclk_a = 1'b0; mclk_b = 1'b0;
        ja = (ja + 1) % 16; jb = (jb + 1) % 16;
        mdat_a = pat_bit(ja, dens_a);
        mdat_b = pat_bit(jb, dens_b);
      end else if (ph == 2) begin
        mclk_a = 1'b1; mclk_b = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic ch, input logic [3:0] code, input logic cal);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = ch; cfg_mode = code; cfg_cal = cal;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic release_cs(input string req);
    conv_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sdat_oe == 1'b0, req, int'(sdat_oe), 0);
  endtask

  task automatic convert(input logic ch, output int word, output int busy);
    int lead;
    @(negedge clk);
    chan_sel = ch;
    @(negedge clk);
    conv_n = 1'b0;
    busy = 0;
    repeat (4) begin @(negedge clk); busy++; end
    check(sdat_oe && !sdat, "R2 busy", {30'd0, sdat_oe, sdat}, 2);
    while (!sdat && busy < 4000) begin @(negedge clk); busy++; end
    lead = int'(sdat);
    word = 0;
    for (int i = 0; i < 16; i++) begin
      sclk_pulse();
      if (i < 15) word = (word << 1) | int'(sdat);
    end
    check(lead == 1 && sdat == 1'b0, "R5 lead/tail", lead * 2 + int'(sdat), 2);
    release_cs("R6 release");
  endtask

  function automatic int expect_raw(input int k);
    return (k >= 16) ? 32767 : k * 2048;
  endfunction

  function automatic int clamp(input int v);
    return (v < 0) ? 0 : ((v > 32767) ? 32767 : v);
  endfunction

  task automatic check_word(input int act, input int exp, input string req);
    int d = act - exp;
    check(d <= 1 && d >= -1, req, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] codes[5] = '{4'b0101, 4'b0011, 4'b1110, 4'b1100, 4'b1010};
    int logs[5] = '{8, 7, 6, 5, 4};
    int ks[5] = '{0, 5, 8, 13, 16};
    int w, b, lo;
    repeat (5) @(negedge clk);
    check(sdat_oe == 1'b0 && sdat == 1'b0, "R2 reset", {30'd0, sdat_oe, sdat}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R3/R4/R1: every mode against several densities on input A; B carries the complement
    for (int m = 0; m < 5; m++) begin
      cfg_write(1'b0, codes[m], 1'b0);
      for (int d = 0; d < 5; d++) begin
        dens_a = ks[d]; dens_b = 16 - ks[d];
        convert(1'b0, w, b);
        check_word(w, expect_raw(ks[d]), "R4 mean");
        lo = ((2 << logs[m]) - 2) * 4;
        check(b >= lo && b <= lo + 14, "R3 window", b, lo);
      end
    end

    // R1: input B selected, A differs
    cfg_write(1'b1, 4'b1010, 1'b0);
    dens_a = 12; dens_b = 3;
    convert(1'b1, w, b);
    check_word(w, 6144, "R1 chan B");
    check(b <= 30 * 4 + 14, "R3 chan B mode", b, 120);

    // R7: illegal code ignored (A stays at M=16)
    cfg_write(1'b0, 4'b0000, 1'b1);
    dens_a = 8;
    convert(1'b0, w, b);
    check(b <= 30 * 4 + 14, "R7 illegal code", b, 120);
    check_word(w, 16384, "R7 cal bit untouched");

    // R8/R9: calibrate B, then apply
    cfg_write(1'b1, 4'b1010, 1'b1);
    dens_b = 6;
    convert(1'b1, w, b);
    check_word(w, 12288, "R8 cal reports raw");
    cfg_write(1'b1, 4'b1010, 1'b0);
    dens_b = 8;
    convert(1'b1, w, b);
    check_word(w, clamp(16384 - 12288 + 16384), "R9 offset applied");
    dens_a = 8;
    convert(1'b0, w, b);
    check_word(w, 16384, "R9 channel isolation");

    // R8 last wins, R9 low clamp
    cfg_write(1'b1, 4'b1010, 1'b1);
    dens_b = 2;
    convert(1'b1, w, b);
    dens_b = 16;
    convert(1'b1, w, b);
    check_word(w, 32767, "R8 second cal");
    cfg_write(1'b1, 4'b1010, 1'b0);
    dens_b = 0;
    convert(1'b1, w, b);
    check_word(w, 0, "R9 low clamp");
    dens_b = 16;
    convert(1'b1, w, b);
    check_word(w, 16384, "R9 full minus full");

    // R9 high clamp on A
    cfg_write(1'b0, 4'b1100, 1'b1);
    dens_a = 0;
    convert(1'b0, w, b);
    check_word(w, 0, "R8 cal zero");
    cfg_write(1'b0, 4'b1100, 1'b0);
    dens_a = 16;
    convert(1'b0, w, b);
    check_word(w, 32767, "R9 high clamp");
    dens_a = 4;
    convert(1'b0, w, b);
    check_word(w, 24576, "R9 offset zero");

    // R6: abort while busy
    @(negedge clk);
    chan_sel = 1'b0;
    conv_n = 1'b0;
    repeat (20) @(negedge clk);
    release_cs("R6 abort busy");

    // R6: abort mid-shift
    conv_n = 1'b0;
    b = 0;
    while (!sdat && b < 4000) begin @(negedge clk); b++; end
    repeat (5) sclk_pulse();
    release_cs("R6 abort shift");

    // normal conversion after aborts
    dens_a = 8;
    convert(1'b0, w, b);
    check_word(w, 32767, "R9 after abort");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule